// File: doc/BRIEF.md
# Disk DMA Request Bridge

This block links the byte handshake of a floppy disk controller to a host bus whose DMA requests are two shared, active-low lines: one asks the host to take a byte in, and the other asks the host to give a byte out. Software sets the bridge up with two register writes. A control write picks the transfer mode and switches the drive motor. A count write gives the transfer length in 128-byte blocks and arms the bridge.

While it is armed, each byte request from the controller is passed to the host line that matches the mode. The bridge releases that line when the host acknowledges the byte, and counts the byte. The mode code selects the transfer:

| Code | Transfer |
|------|----------|
| 0 | none |
| 1 | CRC check only |
| 2 | memory to disk, on the out line (this is also how format ID bytes are supplied) |
| 3 | disk to memory, on the in line |

When the last byte has been serviced, the bridge raises terminal count to the controller. It then ignores requests until the count is written again.

The request lines are open-drain. The bridge only ever pulls a line low or lets it float, and an external pull-up holds the line high. Several boards can therefore share the same line.

The control flow is a four-state machine:

- IDLE: nothing is armed.
- ARMED: the bridge waits for a controller request.
- REQ: a host line is held low until the host acknowledges.
- DONE: terminal count is high.

Its transitions are:

- LOAD: a count write with a nonzero block count goes to ARMED, from any state.
- CLEAR: a count write of zero goes to IDLE.
- FORWARD: ARMED goes to REQ when the controller requests a byte in mode 2 or 3.
- SERVE: REQ goes back to ARMED on an acknowledge while bytes remain.
- FINISH: REQ goes to DONE on the acknowledge of the last byte.

Top module: `disk_dma_bridge`

## Requirements
- R1: A control write (ctl_wr) takes the mode from host_wdata[1:0] and the motor bit from host_wdata[2]. motor_on shows the new bit from the clock after the write.
- R2: A count write (cnt_wr) loads host_wdata as a number of blocks and arms a transfer of blocks×128 bytes. A count of zero disarms the bridge, leaves fdc_tc low and forwards no request.
- R3: In mode 3 only dma_in_n is pulled low for a byte. In mode 2 only dma_out_n is pulled low for a byte. The two lines are never pulled at the same time.
- R4: While armed in mode 2 or 3, a controller request sampled at a clock edge pulls the host line low by the next clock edge.
- R5: Mode 0 (no transfer) and mode 1 (CRC check) never pull either host line.
- R6: The host lines are open-drain: they are only pulled low or released. A low level driven by another board on a released line is read as low.
- R7: After blocks×128 acknowledged bytes, fdc_tc goes high. fdc_tc stays high, and requests are ignored, until the next count write.
- R8: The host line is released in the cycle after host_ack. Each acknowledge counts exactly one byte.
- R9: After reset both host lines are released, fdc_tc is low, the motor is off and the mode is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wdata | input | 8 | Write data for both registers |
| ctl_wr | input | 1 | Writes the control register |
| cnt_wr | input | 1 | Writes the block count and arms a transfer |
| fdc_req | input | 1 | Byte request from the disk controller |
| host_ack | input | 1 | Host has serviced the current byte |
| fdc_tc | output | 1 | Terminal count to the controller |
| motor_on | output | 1 | Drive motor enable |
| dma_in_n | inout | 1 | Shared active-low disk-to-memory request, open-drain |
| dma_out_n | inout | 1 | Shared active-low memory-to-disk request, open-drain |

## Verification
Directed transfers of one block in each direction prove that the mode selects the right line. They also show that terminal count arrives exactly at byte 128 and not one byte early or late. Randomly chosen block counts of 1 to 3 and random modes show that the length really scales with the count, and that the forwarding and quiet modes are told apart. Corner cases cover several points:

- Requests held high in modes 0 and 1.
- Requests held high after terminal count.
- A count write of zero.
- A reload from DONE.
- Another board pulling a released line low, which shows that the bridge never drives a line high.

// File: rtl/dma_bridge_pkg.sv
package dma_bridge_pkg;
    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,
        MODE_CRC  = 2'd1,
        MODE_MTOD = 2'd2,
        MODE_DTOM = 2'd3
    } xfer_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_REQ   = 2'd2,
        ST_DONE  = 2'd3
    } bridge_state_t;
endpackage

// File: rtl/dma_host_regs.sv
module dma_host_regs
    import dma_bridge_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ctl_wr,
    output xfer_mode_t        mode_q,
    output logic              motor_q
);
    // Control register: mode in [1:0], motor in [2].
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= MODE_NONE;
            motor_q <= 1'b0;
        end else if (ctl_wr) begin
            mode_q  <= xfer_mode_t'(wdata[1:0]);
            motor_q <= wdata[2];
        end
    end
endmodule

// File: rtl/dma_byte_counter.sv
module dma_byte_counter #(
    parameter int BLOCK_W     = 8,
    parameter int BLOCK_BYTES = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [BLOCK_W-1:0] blocks,
    input  logic               dec,
    output logic               last
);
    localparam int SHIFT = $clog2(BLOCK_BYTES);
    localparam int CNT_W = BLOCK_W + SHIFT;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= {blocks, {SHIFT{1'b0}}};
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/dma_od_pad.sv
module dma_od_pad (
    input  logic pull,
    inout  wire  pad
);
    // Pulls the line low or releases it; the line is never driven high.
    assign pad = pull ? 1'b0 : 1'bz;
endmodule

// File: rtl/dma_req_fsm.sv
module dma_req_fsm
    import dma_bridge_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_wr,
    input  logic          count_zero,
    input  logic          fdc_req,
    input  logic          host_ack,
    input  logic          last,
    input  xfer_mode_t    mode,
    output bridge_state_t state,
    output logic          load,
    output logic          dec,
    output logic          pull_in,
    output logic          pull_out,
    output logic          tc
);
    bridge_state_t nxt;
    logic          forwarding;

    // Only modes 2 and 3 move data through the host lines.
    assign forwarding = (mode == MODE_MTOD) || (mode == MODE_DTOM);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = ST_IDLE;
            ST_ARMED: if (fdc_req && forwarding) nxt = ST_REQ;
            ST_REQ:   if (host_ack) nxt = last ? ST_DONE : ST_ARMED;
            ST_DONE:  nxt = ST_DONE;
        endcase
        if (cnt_wr)
            nxt = count_zero ? ST_IDLE : ST_ARMED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        load     = cnt_wr;
        dec      = 1'b0;
        pull_in  = 1'b0;
        pull_out = 1'b0;
        tc       = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ARMED: ;
            ST_REQ: begin
                pull_in  = (mode == MODE_DTOM);
                pull_out = (mode == MODE_MTOD);
                dec      = host_ack && !cnt_wr;
            end
            ST_DONE:  tc = 1'b1;
        endcase
    end
endmodule

// File: rtl/disk_dma_bridge.sv
module disk_dma_bridge
    import dma_bridge_pkg::*;
#(
    parameter int BLOCK_W     = 8,
    parameter int BLOCK_BYTES = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BLOCK_W-1:0] host_wdata,
    input  logic               ctl_wr,
    input  logic               cnt_wr,
    input  logic               fdc_req,
    input  logic               host_ack,
    output logic               fdc_tc,
    output logic               motor_on,
    inout  wire                dma_in_n,
    inout  wire                dma_out_n
);
    xfer_mode_t    mode_q;
    bridge_state_t state;
    logic          load, dec, last, pull_in, pull_out;

    dma_host_regs #(.DATA_W(BLOCK_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wdata(host_wdata), .ctl_wr(ctl_wr),
        .mode_q(mode_q), .motor_q(motor_on)
    );

    dma_byte_counter #(.BLOCK_W(BLOCK_W), .BLOCK_BYTES(BLOCK_BYTES)) cnt_i (
        .clk(clk), .rst_n(rst_n), .load(load), .blocks(host_wdata),
        .dec(dec), .last(last)
    );

    dma_req_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr),
        .count_zero(host_wdata == '0), .fdc_req(fdc_req), .host_ack(host_ack),
        .last(last), .mode(mode_q), .state(state), .load(load), .dec(dec),
        .pull_in(pull_in), .pull_out(pull_out), .tc(fdc_tc)
    );

    dma_od_pad in_pad_i  (.pull(pull_in),  .pad(dma_in_n));
    dma_od_pad out_pad_i (.pull(pull_out), .pad(dma_out_n));
endmodule

// File: rtl/dma_bridge_chk.sv
module dma_bridge_chk
    import dma_bridge_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_wr,
    input logic          cnt_wr,
    input logic          fdc_req,
    input logic          host_ack,
    input logic          fdc_tc,
    input logic          dma_in_n,
    input logic          dma_out_n,
    input xfer_mode_t    mode_q,
    input bridge_state_t state,
    input logic          pull_in,
    input logic          pull_out
);
    // R5
    quiet_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_NONE || mode_q == MODE_CRC) |-> !(pull_in || pull_out));

    // R3
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pull_in && pull_out));

    // R6
    od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_in |-> dma_in_n == 1'b0) and (pull_out |-> dma_out_n == 1'b0));

    // R4
    forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && fdc_req && mode_q[1] && !cnt_wr && !ctl_wr)
        |=> (pull_in || pull_out));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pull_in || pull_out) && host_ack) |=> !(pull_in || pull_out));

    // R7
    tc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fdc_tc && !cnt_wr) |=> (fdc_tc && !pull_in && !pull_out));
endmodule

bind disk_dma_bridge dma_bridge_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .cnt_wr(cnt_wr),
    .fdc_req(fdc_req), .host_ack(host_ack), .fdc_tc(fdc_tc),
    .dma_in_n(dma_in_n), .dma_out_n(dma_out_n), .mode_q(mode_q),
    .state(state), .pull_in(pull_in), .pull_out(pull_out)
);

// File: tb/disk_dma_bridge_tb_top.sv
`timescale 1ns/1ps
module disk_dma_bridge_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       ctl_wr = 1'b0, cnt_wr = 1'b0, fdc_req = 1'b0, host_ack = 1'b0;
    logic       other_pull = 1'b0;
    logic       fdc_tc, motor_on;
    wire        dma_in_n, dma_out_n;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    pullup pu_in (dma_in_n);
    pullup pu_out (dma_out_n);
    // Another board sharing the out line.
    assign dma_out_n = other_pull ? 1'b0 : 1'bz;

    always #5 clk = ~clk;

    disk_dma_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .host_wdata(host_wdata), .ctl_wr(ctl_wr),
        .cnt_wr(cnt_wr), .fdc_req(fdc_req), .host_ack(host_ack),
        .fdc_tc(fdc_tc), .motor_on(motor_on),
        .dma_in_n(dma_in_n), .dma_out_n(dma_out_n)
    );

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_bytes(int blocks);
        return blocks * 128;
    endfunction

    // Expected level on each line while a byte is requested: low only for the forwarded direction.
    function automatic bit exp_in_low(int mode);
        return mode == 3;
    endfunction
    function automatic bit exp_out_low(int mode);
        return mode == 2;
    endfunction

    task automatic write_ctl(int mode, bit motor);
        @(negedge clk);
        host_wdata = {5'd0, motor, 2'(mode)};
        ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic write_cnt(int blocks);
        @(negedge clk);
        host_wdata = 8'(blocks);
        cnt_wr = 1'b1;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    // Runs an armed transfer in a forwarding mode and checks every byte.
    task automatic xfer(int mode, int blocks, string req);
        int nbytes = exp_bytes(blocks);
        int bad_line = 0, bad_rel = 0, early_tc = 0;
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            fdc_req = 1'b1;
            @(negedge clk);
            if (dma_in_n !== !exp_in_low(mode) || dma_out_n !== !exp_out_low(mode))
                bad_line++;
            fdc_req = 1'b0;
            host_ack = 1'b1;
            @(negedge clk);
            host_ack = 1'b0;
            if (dma_in_n !== 1'b1 || dma_out_n !== 1'b1) bad_rel++;
            if (i < nbytes - 1 && fdc_tc !== 1'b0) early_tc++;
        end
        check(bad_line == 0, {req, " R3 R4 line low per byte"}, bad_line, 0);
        check(bad_rel == 0, {req, " R8 release after ack"}, bad_rel, 0);
        check(early_tc == 0, {req, " R7 no early tc"}, early_tc, 0);
        check(fdc_tc === 1'b1, {req, " R7 tc after last byte"}, int'(fdc_tc), 1);
    endtask

    // Holds a request for several cycles and expects both lines to stay released.
    task automatic hold_quiet(string req);
        int pulled = 0;
        @(negedge clk);
        fdc_req = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (dma_in_n !== 1'b1 || dma_out_n !== 1'b1) pulled++;
        end
        fdc_req = 1'b0;
        check(pulled == 0, req, pulled, 0);
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        // R9 reset state
        check(dma_in_n === 1'b1 && dma_out_n === 1'b1, "R9 lines released",
              int'({dma_in_n, dma_out_n}), 3);
        check(fdc_tc === 1'b0, "R9 tc low", int'(fdc_tc), 0);
        check(motor_on === 1'b0, "R9 motor off", int'(motor_on), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 not armed after reset: request ignored
        hold_quiet("R2 unarmed after reset ignores request");

        // R1 motor and mode
        write_ctl(3, 1'b1);
        check(motor_on === 1'b1, "R1 motor on", int'(motor_on), 1);
        write_cnt(1);
        check(fdc_tc === 1'b0, "R2 tc low after arm", int'(fdc_tc), 0);
        xfer(3, 1, "mode3 one block");
        // R7 ignored after terminal count
        hold_quiet("R7 request ignored after tc");
        check(fdc_tc === 1'b1, "R7 tc held", int'(fdc_tc), 1);

        // R6 another board pulls the shared line low while released
        @(negedge clk);
        other_pull = 1'b1;
        @(negedge clk);
        check(dma_out_n === 1'b0, "R6 shared line low from other board", int'(dma_out_n), 0);
        other_pull = 1'b0;
        @(negedge clk);
        check(dma_out_n === 1'b1, "R6 line back high via pull-up", int'(dma_out_n), 1);

        // Reload from DONE, mode 2
        write_ctl(2, 1'b0);
        check(motor_on === 1'b0, "R1 motor off", int'(motor_on), 0);
        write_cnt(1);
        check(fdc_tc === 1'b0, "R7 tc cleared by count write", int'(fdc_tc), 0);
        xfer(2, 1, "mode2 one block");

        // R5 modes 0 and 1 stay quiet while armed
        write_ctl(0, 1'b1);
        write_cnt(2);
        hold_quiet("R5 mode 0 no request");
        write_ctl(1, 1'b1);
        hold_quiet("R5 mode 1 CRC no request");
        check(fdc_tc === 1'b0, "R5 no progress in quiet mode", int'(fdc_tc), 0);

        // R2 zero count disarms
        write_ctl(3, 1'b0);
        write_cnt(0);
        hold_quiet("R2 zero count ignores request");
        check(fdc_tc === 1'b0, "R2 zero count leaves tc low", int'(fdc_tc), 0);

        // Random transfers
        for (int k = 0; k < 4; k++) begin
            int m = 2 + int'($urandom_range(1, 0));
            int b = int'($urandom_range(3, 1));
            write_ctl(m, 1'($urandom_range(1, 0)));
            write_cnt(b);
            xfer(m, b, $sformatf("random mode%0d blocks%0d", m, b));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule